// File: doc/BRIEF.md
# Debug-Port Insertion Sub-TAP

This block is a secondary JTAG test access port that sits in the child scan chain behind a master TAP. It runs its own TAP controller, holds a 5-bit instruction register and a 1-bit bypass register, and adds a 32-bit configuration data register. Bit 0 of that register decides whether an auxiliary debug-port TAP is spliced into the scan path between this TAP's serial output and the block's `tdo_o` pin.

The auxiliary TAP shares the same TCK and TMS. It has a 4-bit instruction register and a 32-bit identification register holding 0x4BA00477. It is hidden after any reset. Software makes it visible by loading 1 into the configuration register, and hides it again by loading 0. Inserting it lengthens both the IR path (by 4 bits) and the DR path (by its selected data register). A debugger therefore has to rescan the chain after each change.

Top module: `dpins_sub_tap`

## Requirements
- R1: After `rst_ni` is asserted, the instruction register holds 5'h1F (a bypass code), the configuration register is 0 and the auxiliary TAP is hidden, so a DR scan sees a single bypass bit that captures 0.
- R2: In Capture-IR the 5-bit main instruction shift register loads 5'b00001. While the auxiliary TAP is inserted, its 4-bit IR captures 4'b0001 and lies between the main IR and `tdo_o`, so the IR path is 9 bits long.
- R3: Instruction 5'h12 selects the 32-bit configuration register. Capture-DR loads its current value, bits are shifted LSB first from `tdi_i` towards `tdo_o`, and Update-DR stores the shifted value.
- R4: Every main instruction other than 5'h12 selects the 1-bit bypass register, which captures 0.
- R5: Configuration bit 0 enables the auxiliary TAP: 1 places it in the chain after the main TAP and 0 removes it. Bits 31:1 read back as written and have no other effect.
- R6: The insertion state changes only in Update-DR with instruction 5'h12, or on a reset. The path length during the Shift-DR of the write that inserts the TAP is still the old length.
- R7: The auxiliary IR is 4 bits wide. Code 4'hE selects the 32-bit identification register, which captures 0x4BA00477. Every other code selects a 1-bit bypass register that captures 0.
- R8: While hidden, the auxiliary TAP is held in reset, so each new insertion starts with its IR at 4'hE.
- R9: Five TCK cycles with TMS high reach Test-Logic-Reset from any state. This clears the configuration register, removes the auxiliary TAP and sets the main IR to 5'h1F.
- R10: During Shift-IR and Shift-DR, `tdo_o` presents the bit of the active path that sits nearest the output, before the next rising TCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tms_i | input | 1 | Test mode select, sampled on rising TCK |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, from the auxiliary TAP when inserted, else from the main TAP |

## Verification
The assertions take for granted the following about the inputs:
- TMS and TDI change only away from the rising TCK edge.
- `rst_ni` is an asynchronous reset to Test-Logic-Reset.
- The five-ones property counts edges with TMS high, so it needs clean TMS levels at the edges.

The stimulus drives TMS and TDI on the falling edge and samples `tdo_o` there too. Every scan starts and ends in Run-Test/Idle. The bench models the scan path as a bit queue that is rebuilt at each capture from the modelled insertion state. Each scan is sized to overrun the expected path length, so any change in path length shows up as the bench's own data reappearing at the output.

// File: rtl/dpins_pkg.sv
package dpins_pkg;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SHIFT_DR, TAP_EXIT1_DR, TAP_PAUSE_DR, TAP_EXIT2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SHIFT_IR, TAP_EXIT1_IR, TAP_PAUSE_IR, TAP_EXIT2_IR, TAP_UPD_IR
  } tap_state_e;

  typedef struct packed {
    logic reset;
    logic capture_dr;
    logic shift_dr;
    logic update_dr;
    logic capture_ir;
    logic shift_ir;
    logic update_ir;
  } tap_ctl_t;

  localparam logic [31:0] AUX_IDCODE_DEF = 32'h4BA0_0477;

endpackage

// File: rtl/dpins_tap_fsm.sv
module dpins_tap_fsm
  import dpins_pkg::*;
(
  input  logic     tck_i,
  input  logic     rst_ni,
  input  logic     tms_i,
  output tap_ctl_t ctl_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TAP_RESET:    state_d = tms_i ? TAP_RESET    : TAP_IDLE;
      TAP_IDLE:     state_d = tms_i ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_DR:   state_d = tms_i ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   state_d = tms_i ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: state_d = tms_i ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_EXIT1_DR: state_d = tms_i ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: state_d = tms_i ? TAP_EXIT2_DR : TAP_PAUSE_DR;
      TAP_EXIT2_DR: state_d = tms_i ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   state_d = tms_i ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_IR:   state_d = tms_i ? TAP_RESET    : TAP_CAP_IR;
      TAP_CAP_IR:   state_d = tms_i ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: state_d = tms_i ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_EXIT1_IR: state_d = tms_i ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: state_d = tms_i ? TAP_EXIT2_IR : TAP_PAUSE_IR;
      TAP_EXIT2_IR: state_d = tms_i ? TAP_UPD_IR   : TAP_SHIFT_IR;
      TAP_UPD_IR:   state_d = tms_i ? TAP_SEL_DR   : TAP_IDLE;
      default:      state_d = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TAP_RESET;
    else         state_q <= state_d;
  end

  assign ctl_o.reset      = (state_q == TAP_RESET);
  assign ctl_o.capture_dr = (state_q == TAP_CAP_DR);
  assign ctl_o.shift_dr   = (state_q == TAP_SHIFT_DR);
  assign ctl_o.update_dr  = (state_q == TAP_UPD_DR);
  assign ctl_o.capture_ir = (state_q == TAP_CAP_IR);
  assign ctl_o.shift_ir   = (state_q == TAP_SHIFT_IR);
  assign ctl_o.update_ir  = (state_q == TAP_UPD_IR);

  // consecutive TMS-high edges, checker only
  logic [2:0] tms_ones_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                      tms_ones_q <= '0;
    else if (!tms_i)                  tms_ones_q <= '0;
    else if (tms_ones_q != 3'd5)      tms_ones_q <= tms_ones_q + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_ones_q == 3'd5) |-> (state_q == TAP_RESET)); // R9

endmodule

// File: rtl/dpins_scan_reg.sv
module dpins_scan_reg #(
  parameter int W = 1
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         tdi_i,
  input  logic [W-1:0] cap_val_i,
  output logic [W-1:0] q_o
);

  generate
    if (W == 1) begin : g_bit
      always_ff @(posedge tck_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else if (en_i) begin
          if (capture_i)    q_o <= cap_val_i;
          else if (shift_i) q_o <= tdi_i;
        end
      end
    end else begin : g_vec
      always_ff @(posedge tck_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else if (en_i) begin
          if (capture_i)    q_o <= cap_val_i;
          else if (shift_i) q_o <= {tdi_i, q_o[W-1:1]};
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dpins_aux_tap.sv
module dpins_aux_tap #(
  parameter int          IR_W     = 4,
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] IDCODE = 32'h4BA0_0477,
  parameter logic [IR_W-1:0] ID_INS = 4'hE
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tlr_i,
  input  logic capture_dr_i,
  input  logic shift_dr_i,
  input  logic capture_ir_i,
  input  logic shift_ir_i,
  input  logic update_ir_i,
  input  logic tdi_i,
  output logic tdo_o
);

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] ir_sh, ir_q;
  logic [ID_W-1:0] id_sh;
  logic            bp_q, id_sel;

  assign id_sel = (ir_q == ID_INS);

  dpins_scan_reg #(.W(IR_W)) u_ir_sh (
    .tck_i, .rst_ni, .en_i(active_i), .capture_i(capture_ir_i), .shift_i(shift_ir_i),
    .tdi_i, .cap_val_i(IR_CAPTURE), .q_o(ir_sh));

  dpins_scan_reg #(.W(ID_W)) u_id_sh (
    .tck_i, .rst_ni, .en_i(active_i && id_sel), .capture_i(capture_dr_i),
    .shift_i(shift_dr_i), .tdi_i, .cap_val_i(IDCODE), .q_o(id_sh));

  dpins_scan_reg #(.W(1)) u_bp (
    .tck_i, .rst_ni, .en_i(active_i && !id_sel), .capture_i(capture_dr_i),
    .shift_i(shift_dr_i), .tdi_i, .cap_val_i(1'b0), .q_o(bp_q));

  // hidden TAP is held in reset
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                  ir_q <= ID_INS;
    else if (tlr_i || !active_i)  ir_q <= ID_INS;
    else if (update_ir_i)         ir_q <= ir_sh;
  end

  assign tdo_o = shift_ir_i ? ir_sh[0] : (id_sel ? id_sh[0] : bp_q);

  AST_HIDDEN_HOLDS_IDCODE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !active_i |=> (ir_q == ID_INS)); // R8

  AST_ID_CAPTURE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (active_i && capture_dr_i && id_sel) |=> (id_sh == IDCODE)); // R7

endmodule

// File: rtl/dpins_sub_tap.sv
module dpins_sub_tap
  import dpins_pkg::*;
#(
  parameter int              IR_W       = 5,
  parameter int              CFG_W      = 32,
  parameter logic [IR_W-1:0] CFG_INS    = 5'h12,
  parameter logic [IR_W-1:0] RST_INS    = 5'h1F,
  parameter int              EN_BIT     = 0,
  parameter int              AUX_IR_W   = 4,
  parameter logic [31:0]     AUX_IDCODE = AUX_IDCODE_DEF,
  parameter logic [AUX_IR_W-1:0] AUX_ID_INS = 4'hE
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o
);

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

  tap_ctl_t         ctl;
  logic [IR_W-1:0]  ir_sh, ir_q;
  logic [CFG_W-1:0] cfg_sh, cfg_q;
  logic             bp_q, cfg_sel, aux_on, main_tdo, aux_tdo;

  dpins_tap_fsm u_fsm (.tck_i, .rst_ni, .tms_i, .ctl_o(ctl));

  assign cfg_sel = (ir_q == CFG_INS);

  dpins_scan_reg #(.W(IR_W)) u_ir_sh (
    .tck_i, .rst_ni, .en_i(1'b1), .capture_i(ctl.capture_ir), .shift_i(ctl.shift_ir),
    .tdi_i, .cap_val_i(IR_CAPTURE), .q_o(ir_sh));

  dpins_scan_reg #(.W(CFG_W)) u_cfg_sh (
    .tck_i, .rst_ni, .en_i(cfg_sel), .capture_i(ctl.capture_dr), .shift_i(ctl.shift_dr),
    .tdi_i, .cap_val_i(cfg_q), .q_o(cfg_sh));

  dpins_scan_reg #(.W(1)) u_bp (
    .tck_i, .rst_ni, .en_i(!cfg_sel), .capture_i(ctl.capture_dr), .shift_i(ctl.shift_dr),
    .tdi_i, .cap_val_i(1'b0), .q_o(bp_q));

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)            ir_q <= RST_INS;
    else if (ctl.reset)     ir_q <= RST_INS;
    else if (ctl.update_ir) ir_q <= ir_sh;
  end

  // config only moves in Update-DR, so path length is fixed during a shift
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                          cfg_q <= '0;
    else if (ctl.reset)                   cfg_q <= '0;
    else if (ctl.update_dr && cfg_sel)    cfg_q <= cfg_sh;
  end

  assign aux_on   = cfg_q[EN_BIT];
  assign main_tdo = ctl.shift_ir ? ir_sh[0] : (cfg_sel ? cfg_sh[0] : bp_q);

  dpins_aux_tap #(
    .IR_W(AUX_IR_W), .ID_W(32), .IDCODE(AUX_IDCODE), .ID_INS(AUX_ID_INS)
  ) u_aux (
    .tck_i, .rst_ni, .active_i(aux_on), .tlr_i(ctl.reset),
    .capture_dr_i(ctl.capture_dr), .shift_dr_i(ctl.shift_dr),
    .capture_ir_i(ctl.capture_ir), .shift_ir_i(ctl.shift_ir), .update_ir_i(ctl.update_ir),
    .tdi_i(main_tdo), .tdo_o(aux_tdo));

  assign tdo_o = aux_on ? aux_tdo : main_tdo;

  AST_IR_CAPTURE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ctl.capture_ir |=> (ir_sh == IR_CAPTURE)); // R2

  AST_BYPASS_ZERO: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ctl.capture_dr && !cfg_sel) |=> (bp_q == 1'b0)); // R4

  AST_INSERT_ON_UPDATE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(ctl.update_dr && cfg_sel) && !ctl.reset |=> $stable(aux_on)); // R6

  AST_TLR_CLEARS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ctl.reset |=> (cfg_q == '0) && !aux_on && (ir_q == RST_INS)); // R9

  AST_CFG_READBACK: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ctl.capture_dr && cfg_sel) |=> (cfg_sh == cfg_q)); // R3

endmodule

// File: tb/dpins_sub_tap_tb.sv
module dpins_sub_tap_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo;

  always #2 clk = ~clk;

  dpins_sub_tap u_dut (.tck_i(clk), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo));

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R10";

  localparam int ST_TLR = 0, ST_IDLE = 1, ST_SDRS = 2, ST_CDR = 3, ST_SDR = 4, ST_E1D = 5,
                 ST_PD = 6, ST_E2D = 7, ST_UDR = 8, ST_SIRS = 9, ST_CIR = 10, ST_SIR = 11,
                 ST_E1I = 12, ST_PI = 13, ST_E2I = 14, ST_UIR = 15;
  localparam logic [31:0] EXP_ID = 32'h4BA0_0477;

  int         ms;
  logic [4:0] m_ir;
  logic [31:0] m_cfg;
  bit         m_aux;
  logic [3:0] m_aux_ir;
  bit         q[$];
  int         q_aux_len;

  function automatic int next_st(int s, bit t);
    case (s)
      ST_TLR:  return t ? ST_TLR  : ST_IDLE;
      ST_IDLE: return t ? ST_SDRS : ST_IDLE;
      ST_SDRS: return t ? ST_SIRS : ST_CDR;
      ST_CDR, ST_SDR: return t ? ST_E1D : ST_SDR;
      ST_E1D:  return t ? ST_UDR  : ST_PD;
      ST_PD:   return t ? ST_E2D  : ST_PD;
      ST_E2D:  return t ? ST_UDR  : ST_SDR;
      ST_SIRS: return t ? ST_TLR  : ST_CIR;
      ST_CIR, ST_SIR: return t ? ST_E1I : ST_SIR;
      ST_E1I:  return t ? ST_UIR  : ST_PI;
      ST_PI:   return t ? ST_E2I  : ST_PI;
      ST_E2I:  return t ? ST_UIR  : ST_SIR;
      default: return t ? ST_SDRS : ST_IDLE;
    endcase
  endfunction

  task automatic model_reset();
    ms = ST_TLR; m_ir = 5'h1F; m_cfg = '0; m_aux = 1'b0; m_aux_ir = 4'hE;
    q.delete(); q_aux_len = 0;
  endtask

  task automatic model_step(input bit t, input bit d);
    if (!m_aux) m_aux_ir = 4'hE;
    case (ms)
      ST_TLR: begin m_ir = 5'h1F; m_cfg = '0; m_aux = 1'b0; m_aux_ir = 4'hE; end
      ST_CDR: begin
        q.delete(); q_aux_len = 0;
        if (m_aux) begin
          if (m_aux_ir == 4'hE) for (int i = 0; i < 32; i++) q.push_back(EXP_ID[i]);
          else q.push_back(1'b0);
          q_aux_len = q.size();
        end
        if (m_ir == 5'h12) for (int i = 0; i < 32; i++) q.push_back(m_cfg[i]);
        else q.push_back(1'b0);
      end
      ST_SDR, ST_SIR: begin void'(q.pop_front()); q.push_back(d); end
      ST_UDR: if (m_ir == 5'h12) begin
        for (int i = 0; i < 32; i++) m_cfg[i] = q[q_aux_len + i];
        m_aux = m_cfg[0];
      end
      ST_CIR: begin
        q.delete(); q_aux_len = 0;
        if (m_aux) begin
          q.push_back(1'b1); for (int i = 0; i < 3; i++) q.push_back(1'b0);
          q_aux_len = 4;
        end
        q.push_back(1'b1); for (int i = 0; i < 4; i++) q.push_back(1'b0);
      end
      ST_UIR: begin
        if (m_aux) for (int i = 0; i < 4; i++) m_aux_ir[i] = q[i];
        for (int i = 0; i < 5; i++) m_ir[i] = q[q_aux_len + i];
      end
      default: ;
    endcase
    ms = next_st(ms, t);
  endtask

  // drive and sample on the falling edge, model advances on the rising edge
  task automatic tick(input bit t, input bit d, output bit o);
    @(negedge clk);
    tms = t; tdi = d;
    o = tdo;
    if (ms == ST_SDR || ms == ST_SIR) begin
      n_chk++;
      if (q.size() == 0 || tdo !== q[0]) begin
        n_fail++;
        $display("FAIL %s: tdo actual %b expected %b", cur_req, tdo, (q.size() != 0) ? q[0] : 1'b0);
      end
    end
    @(posedge clk);
    model_step(t, d);
  endtask

  task automatic scan(input bit is_ir, input int n, input logic [127:0] din,
                      output logic [127:0] dout);
    bit o;
    dout = '0;
    tick(1'b1, 1'b0, o);
    if (is_ir) tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
    tick(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o);
      dout[i] = o;
    end
    tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
  endtask

  task automatic tlr_walk();
    bit o;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] r;
    bit o;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tick(1'b0, 1'b0, o);

    // R1 / R4: reset leaves a 1-bit bypass path capturing 0
    cur_req = "R1";
    scan(1'b0, 8, 8'hB3, r);
    chk("R1", r[7:0], 8'h66);

    // R2: main IR capture pattern
    cur_req = "R2";
    scan(1'b1, 5, 5'h12, r);
    chk("R2", r[4:0], 5'h01);

    // R3: config register after reset, then read-back
    cur_req = "R3";
    scan(1'b0, 32, 32'hA5A5_5A5A, r);
    chk("R1", r[31:0], 32'h0);
    scan(1'b0, 40, {32'h1234_5678, 8'hC3}, r);
    chk("R3", r[31:0], 32'hA5A5_5A5A);
    chk("R5", r[39:32], 8'hC3);

    // R6: inserting write still shifts through the old 32-bit path
    cur_req = "R6";
    scan(1'b0, 40, {32'h0000_0001, 8'h5A}, r);
    chk("R3", r[31:0], 32'h1234_5678);
    chk("R6", r[39:32], 8'h5A);

    // R7 / R5: aux IDCODE appears nearest the output
    cur_req = "R7";
    scan(1'b0, 64, {32'h1, 32'h0}, r);
    chk("R7", r[31:0], EXP_ID);
    chk("R5", r[63:32], 32'h1);

    // R2: 9-bit IR path with aux inserted
    cur_req = "R2";
    scan(1'b1, 9, {5'h12, 4'hF}, r);
    chk("R2", r[8:0], {5'h01, 4'h1});

    // R7 / R5: aux in bypass, config bit 1 reads back
    cur_req = "R5";
    scan(1'b0, 33, {32'h3, 1'b0}, r);
    chk("R7", r[0], 1'b0);
    chk("R5", r[32:1], 32'h1);
    scan(1'b0, 33, {32'h1, 1'b0}, r);
    chk("R5", r[32:1], 32'h3);

    // R4 / R7: unknown codes on both TAPs give a 2-bit path
    cur_req = "R4";
    scan(1'b1, 9, {5'h07, 4'h3}, r);
    chk("R2", r[8:0], {5'h01, 4'h1});
    scan(1'b0, 6, 6'b101101, r);
    chk("R4", r[5:0], 6'h34);

    // R8: remove while aux is in bypass, re-insert, IDCODE is back
    cur_req = "R8";
    scan(1'b1, 9, {5'h12, 4'hF}, r);
    scan(1'b0, 33, {32'h0, 1'b0}, r);
    chk("R5", r[32:1], 32'h1);
    scan(1'b0, 40, {32'h1, 8'h96}, r);
    chk("R5", r[31:0], 32'h0);
    chk("R5", r[39:32], 8'h96);
    scan(1'b0, 64, {32'h1, 32'h0}, r);
    chk("R8", r[31:0], EXP_ID);

    // R9: TMS reset removes aux and clears config
    cur_req = "R9";
    tlr_walk();
    scan(1'b1, 7, {5'h12, 2'b10}, r);
    chk("R9", r[6:0], 7'h41);
    scan(1'b0, 32, 32'h0, r);
    chk("R9", r[31:0], 32'h0);

    // R1: asynchronous reset while inserted
    cur_req = "R1";
    scan(1'b0, 32, 32'h1, r);
    @(negedge clk);
    rst_n = 1'b0; tms = 1'b1;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tick(1'b0, 1'b0, o);
    scan(1'b1, 7, {5'h12, 2'b10}, r);
    chk("R1", r[6:0], 7'h41);
    scan(1'b0, 32, 32'h0, r);
    chk("R1", r[31:0], 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule